// File: doc/BRIEF.md
# Leaky Sample Integrator with Saturation

This block turns a stream of 8-bit offset-binary converter samples into a running integral. Each time the sample strobe is high, the code is made signed by flipping its top bit. The signed value is added to a wide sum that is held in a register and fed back into the adder. A small leak term, the sum shifted arithmetically right by `LEAK_SH`, is subtracted at the same time. Because of the leak, a constant bias settles at a finite level and does not drive the sum to a rail. The sum integrates by sign, not by slope. It grows while the input sits above mid-scale and shrinks while the input sits below mid-scale.

The next sum is clamped to the most positive and most negative values of the accumulator width, so it never wraps. A small state machine records whether a clamp has happened. In `ST_EMPTY` the sum has just been cleared and no sample has arrived yet. In `ST_TRACK` the block is integrating normally. `ST_RAILED` is the sticky saturated state.

The transitions are as follows:
- Clear forces `ST_EMPTY` from any state.
- A sample that does not clamp moves `ST_EMPTY` to `ST_TRACK`.
- A sample that clamps moves `ST_EMPTY` or `ST_TRACK` to `ST_RAILED`.
- `ST_RAILED` is left only by clear.

The upper 8 bits of the sum, with the sign bit inverted, go out as an offset-binary word for a DAC.

Top module: `leaky_integrator`

## Requirements
- R1: Starting from a sum of zero, a sample with a code above 0x80 makes the sum positive and a code below 0x80 makes it negative. A falling input that stays above 0x80 keeps raising the sum.
- R2: A code c contributes the signed value c − 128: its bit 7 is inverted and the byte is read as two's complement. So 0x80 adds 0, 0xFF adds +127, 0x00 adds −128 and 0x7F adds −1.
- R3: On a sample, the new sum is sum + (c − 128) − (sum >>> LEAK_SH), where >>> is an arithmetic right shift. It is then clamped to the range [−32768, +32767]. A LEAK_SH of 0 means no leak.
- R4: When the sample strobe is low, the sum and all outputs hold, whatever the code input does.
- R5: Clear forces the sum to zero and the saturation flag to 0 on the next edge. Clear wins over a sample strobe in the same cycle.
- R6: Under a sustained full-scale input, the sum stops at +32767 or at −32768 and never wraps to the other sign.
- R7: The saturation flag is set by the first sample that clamps. It stays set through later samples, including samples that move the sum off the rail, until clear.
- R8: The DAC word is bits 15..8 of the sum with bit 7 of the word inverted. A zero sum gives 0x80, +32767 gives 0xFF and −32768 gives 0x00.
- R9: With mid-scale input (0x80), a sum whose magnitude is at least 2^LEAK_SH moves strictly toward zero on every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear of the sum and the saturation state |
| smp_vld | input | 1 | Sample strobe; the sum updates only when this is high |
| adc_code | input | 8 | Offset-binary converter code |
| acc_value | output | 16 | Running sum, two's complement |
| dac_code | output | 8 | Offset-binary word for the DAC |
| sat_flag | output | 1 | Sticky flag; high once the sum has clamped |

## Verification
The bench builds the block with LEAK_SH set to 10. With that leak, the resting level for a full-scale input lies beyond the 16-bit range, so both clamps and the sticky flag can be reached in a few hundred samples. Under the default shift of 6 no input can ever saturate the sum. The same setting still lets the leak be seen at the ports: from the positive rail with mid-scale input, each sample removes 31 or fewer counts. Hand-worked short sequences from zero check the exact sign mapping, the arithmetic-shift rounding of negative sums, and the DAC word.

// File: rtl/leaky_integ_pkg.sv
package leaky_integ_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_TRACK  = 2'd1,
        ST_RAILED = 2'd2
    } integ_state_t;

endpackage

// File: rtl/ofs_to_signed.sv
module ofs_to_signed #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0]        code_in,
    output logic signed [CODE_W-1:0] val_out
);
    // Offset binary to two's complement: flip the top bit only.
    always_comb begin
        val_out = $signed({~code_in[CODE_W-1], code_in[CODE_W-2:0]});
    end
endmodule

// File: rtl/leak_sat_adder.sv
module leak_sat_adder #(
    parameter int ACC_W   = 16,
    parameter int CODE_W  = 8,
    parameter int LEAK_SH = 6
) (
    input  logic signed [ACC_W-1:0]  sum_in,
    input  logic signed [CODE_W-1:0] smp_in,
    output logic signed [ACC_W-1:0]  sum_out,
    output logic                     clamped
);
    localparam int EXT_W = ACC_W + 2;
    localparam logic signed [EXT_W-1:0] MAX_V = EXT_W'((2 ** (ACC_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] MIN_V = -EXT_W'(2 ** (ACC_W - 1));

    logic signed [EXT_W-1:0] sum_e;
    logic signed [EXT_W-1:0] smp_e;
    logic signed [EXT_W-1:0] leak_e;
    logic signed [EXT_W-1:0] raw_e;

    always_comb begin
        sum_e = {{2{sum_in[ACC_W-1]}}, sum_in};
        smp_e = {{(EXT_W-CODE_W){smp_in[CODE_W-1]}}, smp_in};
    end

    generate
        if (LEAK_SH == 0) begin : g_no_leak
            always_comb leak_e = '0;
        end else begin : g_leak
            always_comb leak_e = sum_e >>> LEAK_SH;
        end
    endgenerate

    always_comb begin
        raw_e   = sum_e + smp_e - leak_e;
        clamped = 1'b0;
        if (raw_e > MAX_V) begin
            sum_out = MAX_V[ACC_W-1:0];
            clamped = 1'b1;
        end else if (raw_e < MIN_V) begin
            sum_out = MIN_V[ACC_W-1:0];
            clamped = 1'b1;
        end else begin
            sum_out = raw_e[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/leaky_integrator.sv
module leaky_integrator
    import leaky_integ_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int ACC_W   = 16,
    parameter int LEAK_SH = 6
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] adc_code,
    output logic [ACC_W-1:0]  acc_value,
    output logic [CODE_W-1:0] dac_code,
    output logic              sat_flag
);
    localparam int DAC_LSB = ACC_W - CODE_W;

    integ_state_t            state_q;
    integ_state_t            state_nx;
    logic signed [CODE_W-1:0] smp_s;
    logic signed [ACC_W-1:0]  sum_q;
    logic signed [ACC_W-1:0]  sum_nx;
    logic                     clamp_hit;

    ofs_to_signed #(.CODE_W(CODE_W)) u_map (
        .code_in (adc_code),
        .val_out (smp_s)
    );

    leak_sat_adder #(
        .ACC_W   (ACC_W),
        .CODE_W  (CODE_W),
        .LEAK_SH (LEAK_SH)
    ) u_add (
        .sum_in  (sum_q),
        .smp_in  (smp_s),
        .sum_out (sum_nx),
        .clamped (clamp_hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (clr) state_q <= ST_EMPTY;
        else     state_q <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_EMPTY:  if (smp_vld) state_nx = clamp_hit ? ST_RAILED : ST_TRACK;
            ST_TRACK:  if (smp_vld && clamp_hit) state_nx = ST_RAILED;
            ST_RAILED: state_nx = ST_RAILED;
            default:   state_nx = ST_EMPTY;
        endcase
    end

    // Accumulator register fed back through the adder
    always_ff @(posedge clk) begin
        if (clr)          sum_q <= '0;
        else if (smp_vld) sum_q <= sum_nx;
    end

    // Outputs
    always_comb begin
        acc_value = sum_q;
        dac_code  = {~sum_q[ACC_W-1], sum_q[ACC_W-2:DAC_LSB]};
        sat_flag  = (state_q == ST_RAILED);
    end
endmodule

// File: rtl/leaky_integrator_chk.sv
module leaky_integrator_chk #(
    parameter int CODE_W = 8,
    parameter int ACC_W  = 16
) (
    input logic              clk,
    input logic              clr,
    input logic              smp_vld,
    input logic [CODE_W-1:0] adc_code,
    input logic [ACC_W-1:0]  acc_value,
    input logic [CODE_W-1:0] dac_code,
    input logic              sat_flag
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    logic armed = 1'b0;
    always_ff @(posedge clk) if (clr) armed <= 1'b1;

    // R4
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!armed)
        (!smp_vld && !clr) |=> ($stable(acc_value) && $stable(dac_code)));

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        clr |=> (acc_value == '0 && !sat_flag));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!armed || clr)
        sat_flag |=> sat_flag);

    // R7
    flag_needs_sample_chk: assert property (@(posedge clk) disable iff (!armed || clr)
        $rose(sat_flag) |-> $past(smp_vld));

    // R1
    positive_input_chk: assert property (@(posedge clk) disable iff (!armed)
        (smp_vld && !clr && acc_value == '0 && adc_code > MID) |=> $signed(acc_value) > 0);

    // R1
    negative_input_chk: assert property (@(posedge clk) disable iff (!armed)
        (smp_vld && !clr && acc_value == '0 && adc_code < MID) |=> $signed(acc_value) < 0);
endmodule

bind leaky_integrator leaky_integrator_chk #(
    .CODE_W (CODE_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk       (clk),
    .clr       (clr),
    .smp_vld   (smp_vld),
    .adc_code  (adc_code),
    .acc_value (acc_value),
    .dac_code  (dac_code),
    .sat_flag  (sat_flag)
);

// File: tb/tb_leaky_integrator.sv
module tb_leaky_integrator;
    localparam int LEAK = 10;
    localparam int NV   = 8;
    localparam logic [7:0] TV_CODE [NV] = '{8'h90, 8'h90, 8'h70, 8'h00, 8'hFF, 8'h80, 8'hFF, 8'hFF};
    localparam int         TV_SUM  [NV] = '{16, 32, 16, -112, 16, 16, 143, 270};

    logic        clk = 1'b0;
    logic        clr = 1'b0;
    logic        smp_vld = 1'b0;
    logic [7:0]  adc_code = 8'h80;
    logic [15:0] acc_value;
    logic [7:0]  dac_code;
    logic        sat_flag;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    leaky_integrator #(.CODE_W(8), .ACC_W(16), .LEAK_SH(LEAK)) dut (
        .clk(clk), .clr(clr), .smp_vld(smp_vld), .adc_code(adc_code),
        .acc_value(acc_value), .dac_code(dac_code), .sat_flag(sat_flag)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sum_now();
        return int'($signed(acc_value));
    endfunction

    function automatic int dac_of(int s);
        return ((s >>> 8) & 255) ^ 128;
    endfunction

    function automatic int model(int s, int c);
        int r;
        r = s + (c - 128) - (s >>> LEAK);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic sample(logic [7:0] c);
        @(negedge clk);
        adc_code = c;
        smp_vld  = 1'b1;
        @(negedge clk);
        smp_vld  = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int prev;
        int exp;
        bit mono;
        bit dec;
        do_clear();
        chk("R5 reset sum", sum_now(), 0);
        chk("R8 reset dac", int'(dac_code), 128);
        chk("R5 reset flag", int'(sat_flag), 0);

        // Table walk: R1 R2 R3 R8
        for (int i = 0; i < NV; i++) begin
            sample(TV_CODE[i]);
            chk($sformatf("R3 table step %0d sum", i), sum_now(), TV_SUM[i]);
            chk($sformatf("R8 table step %0d dac", i), int'(dac_code), dac_of(TV_SUM[i]));
        end

        // R4: code changes without strobe
        @(negedge clk);
        adc_code = 8'h00;
        repeat (3) @(negedge clk);
        adc_code = 8'hFF;
        @(negedge clk);
        chk("R4 hold sum", sum_now(), 270);
        chk("R4 hold dac", int'(dac_code), dac_of(270));

        // R5: clear beats strobe
        @(negedge clk);
        clr = 1'b1;
        smp_vld = 1'b1;
        adc_code = 8'hFF;
        @(negedge clk);
        clr = 1'b0;
        smp_vld = 1'b0;
        chk("R5 clear priority sum", sum_now(), 0);

        // R2 mapping points
        sample(8'h81); chk("R2 code 0x81", sum_now(), 1);
        do_clear();
        sample(8'h7F); chk("R2 code 0x7F", sum_now(), -1);
        do_clear();
        sample(8'h80); chk("R2 code 0x80", sum_now(), 0);

        // R1: falling but positive input still raises the sum
        do_clear();
        mono = 1'b1;
        prev = 0;
        for (int c = 8'hF0; c > 8'h80; c -= 8'h10) begin
            sample(8'(c));
            if (sum_now() <= prev) mono = 1'b0;
            prev = sum_now();
        end
        chk("R1 falling positive input rises", int'(mono), 1);

        // R6 R7: positive rail without wrap
        do_clear();
        exp = 0;
        mono = 1'b1;
        for (int i = 0; i < 600; i++) begin
            sample(8'hFF);
            exp = model(exp, 255);
            if (sum_now() != exp) mono = 1'b0;
        end
        chk("R6 positive rail follows model", int'(mono), 1);
        chk("R6 positive rail value", sum_now(), 32767);
        chk("R8 positive rail dac", int'(dac_code), 255);
        chk("R7 flag set at positive rail", int'(sat_flag), 1);

        // R9: decay toward zero with mid-scale input; R7 flag stays
        dec = 1'b1;
        prev = sum_now();
        for (int i = 0; i < 20; i++) begin
            sample(8'h80);
            if (!(sum_now() < prev && sum_now() > 0)) dec = 1'b0;
            prev = sum_now();
        end
        chk("R9 positive sum decays", int'(dec), 1);
        chk("R3 decay value", sum_now(), prev);
        chk("R7 flag sticky off rail", int'(sat_flag), 1);
        do_clear();
        chk("R7 clear drops flag", int'(sat_flag), 0);

        // R6: negative rail
        exp = 0;
        for (int i = 0; i < 600; i++) begin
            sample(8'h00);
            exp = model(exp, 0);
        end
        chk("R6 negative rail value", sum_now(), -32768);
        chk("R6 negative rail model", sum_now(), exp);
        chk("R8 negative rail dac", int'(dac_code), 0);
        chk("R7 flag set at negative rail", int'(sat_flag), 1);

        // R9: negative side decays upward
        dec = 1'b1;
        prev = sum_now();
        for (int i = 0; i < 10; i++) begin
            sample(8'h80);
            if (!(sum_now() > prev && sum_now() < 0)) dec = 1'b0;
            prev = sum_now();
        end
        chk("R9 negative sum decays", int'(dec), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule